// File: doc/BRIEF.md
# Bridge Data Parity Error Signaler

This block decides, for a two-sided PCI-to-PCI bridge, when a data parity error must be reported on the secondary bus through PERR# and when it must go up to the host as a system error through the primary SERR#. Each data phase that carries a parity verdict is presented as a one-cycle descriptor: transaction kind, direction, the bus on which the error was seen, the bridge's own parity check result and the PERR# levels sampled on both buses. The parity response and system error enables arrive as static configuration levels.

The secondary PERR# pin is driven low for one clock a fixed two cycles after the descriptor, then driven high for one clock and released. The primary SERR# pin is open drain: the block only pulls it low for one clock per reported event. Two sticky flags record that a parity error was signalled and that a system error was raised. Software clears them with one-cycle clear pulses.

Top module: `bridge_parity_signal`

## Requirements
- R1: After a synchronous active-low reset, sec_perr_oe and pri_serr_oe are 0, sec_perr_n is 1 and both sticky flags are 0.
- R2: A secondary-bus error (err_on_sec=1, par_bad=1) with sec_per_en=1 reports PERR# when the bridge is the read initiator there (xact_kind=0 read, xact_up=0) or the write target there (xact_kind=1 posted or 2 delayed write, xact_up=1).
- R3: A secondary-bus error on an upstream read or on a downstream posted or delayed write produces no PERR#.
- R4: For errors on the primary bus (err_on_sec=0), PERR# is reported only for an upstream delayed write whose completion saw primary PERR# asserted (pri_perr_seen=1). The bridge's own bad parity on the primary bus never reports.
- R5: With sec_per_en=0, no PERR# is reported for any descriptor.
- R6: For a descriptor sampled at clock edge e, sec_perr_n is low for exactly the period from edge e+2 to e+3, driven high from e+3 to e+4 (sec_perr_oe=1 in both), and released (sec_perr_oe=0) after edge e+4.
- R7: An upstream posted write with the error on the primary bus and pri_perr_seen=1, or a downstream posted write with the error on the secondary bus and sec_perr_seen=1, asserts pri_serr_oe for the single period from edge e to e+1. This requires pri_per_en, sec_per_en and serr_en all set.
- R8: SERR# is not raised when src_par_bad=1 (the bridge itself saw bad parity as target of that write), when any of the three enables is 0, or for a transaction that is not a posted write.
- R9: det_flag becomes 1 after the edge that samples a PERR#-reporting descriptor and holds until a clr_det_flag pulse. A simultaneous set and clear leaves it 1.
- R10: sys_flag becomes 1 after the edge that samples a SERR#-raising descriptor and holds until a clr_sys_flag pulse. A simultaneous set and clear leaves it 1.
- R11: Reporting descriptors on consecutive edges give consecutive low PERR# periods. The single driven-high period follows only the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xact_valid | input | 1 | Descriptor valid for this data phase |
| xact_kind | input | 2 | 0 read, 1 posted write, 2 delayed write, 3 ignored |
| xact_up | input | 1 | 1 upstream, 0 downstream |
| err_on_sec | input | 1 | 1 error seen on secondary bus, 0 on primary bus |
| par_bad | input | 1 | Bridge parity check failed on the named bus |
| src_par_bad | input | 1 | Bridge saw bad parity as target of this posted write |
| pri_perr_seen | input | 1 | Primary PERR# sampled asserted |
| sec_perr_seen | input | 1 | Secondary PERR# sampled asserted |
| pri_per_en | input | 1 | Command register parity response enable |
| sec_per_en | input | 1 | Secondary bridge control parity response enable |
| serr_en | input | 1 | System error enable |
| clr_det_flag | input | 1 | Clear pulse for det_flag |
| clr_sys_flag | input | 1 | Clear pulse for sys_flag |
| sec_perr_n | output | 1 | Secondary PERR# level when driven |
| sec_perr_oe | output | 1 | Secondary PERR# output enable |
| pri_serr_oe | output | 1 | Pull primary SERR# low when 1 |
| det_flag | output | 1 | Sticky parity-error-signalled flag |
| sys_flag | output | 1 | Sticky system-error-raised flag |

## Verification
The hardest case to reach is the overlap of two PERR# pulses. The driven-high cycle of one report would land on the low cycle of the next. The stimulus presents reporting descriptors on two adjacent edges and then watches five following periods, expecting two low periods and one high period at the end. The other difficult case is a far-bus PERR# on a posted write that should become SERR# and not PERR#. Matching cases toggle src_par_bad and each enable in turn.

// File: rtl/bridge_parity_signal.sv
module bridge_parity_signal (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xact_valid,
  input  logic [1:0] xact_kind,
  input  logic       xact_up,
  input  logic       err_on_sec,
  input  logic       par_bad,
  input  logic       src_par_bad,
  input  logic       pri_perr_seen,
  input  logic       sec_perr_seen,
  input  logic       pri_per_en,
  input  logic       sec_per_en,
  input  logic       serr_en,
  input  logic       clr_det_flag,
  input  logic       clr_sys_flag,
  output logic       sec_perr_n,
  output logic       sec_perr_oe,
  output logic       pri_serr_oe,
  output logic       det_flag,
  output logic       sys_flag
);
  localparam logic [1:0] KIND_RD = 2'd0;
  localparam logic [1:0] KIND_PW = 2'd1;
  localparam logic [1:0] KIND_DW = 2'd2;

  logic is_rd, is_pw, is_dw;
  logic sec_hit, cpl_hit, far_hit;
  logic fire_perr, fire_serr;
  logic stg1, stg2, perr_lo, perr_hi, serr_lo;

  assign is_rd = (xact_kind == KIND_RD);
  assign is_pw = (xact_kind == KIND_PW);
  assign is_dw = (xact_kind == KIND_DW);

  // bridge is read initiator or write target on the secondary bus
  assign sec_hit = err_on_sec && par_bad &&
                   ((is_rd && !xact_up) || ((is_pw || is_dw) && xact_up));
  // upstream delayed write completion saw primary PERR#
  assign cpl_hit = !err_on_sec && is_dw && xact_up && pri_perr_seen;
  // PERR# on the far side of a posted write
  assign far_hit = is_pw && ((xact_up && !err_on_sec && pri_perr_seen) ||
                             (!xact_up && err_on_sec && sec_perr_seen));

  assign fire_perr = xact_valid && sec_per_en && (sec_hit || cpl_hit);
  assign fire_serr = xact_valid && pri_per_en && sec_per_en && serr_en &&
                     far_hit && !src_par_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1     <= 1'b0;
      stg2     <= 1'b0;
      perr_lo  <= 1'b0;
      perr_hi  <= 1'b0;
      serr_lo  <= 1'b0;
      det_flag <= 1'b0;
      sys_flag <= 1'b0;
    end else begin
      stg1     <= fire_perr;
      stg2     <= stg1;
      perr_lo  <= stg2;
      perr_hi  <= perr_lo && !stg2;
      serr_lo  <= fire_serr;
      det_flag <= fire_perr || (det_flag && !clr_det_flag);
      sys_flag <= fire_serr || (sys_flag && !clr_sys_flag);
    end
  end

  assign sec_perr_n  = !perr_lo;
  assign sec_perr_oe = perr_lo || perr_hi;
  assign pri_serr_oe = serr_lo;

  AST_PERR_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_perr_n |-> $past(xact_valid, 3)); // R6
  AST_PERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_perr_n |-> $past(sec_per_en, 3)); // R5
  AST_PERR_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_perr_oe && !$past(sec_perr_oe) && $past(rst_n)) |-> !sec_perr_n); // R6
  AST_PERR_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sec_perr_oe) && $past(rst_n)) |-> $past(sec_perr_n)); // R6
  AST_SERR_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    pri_serr_oe |-> $past(serr_en && pri_per_en && sec_per_en)); // R7
  AST_SERR_POSTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pri_serr_oe |-> $past(xact_valid && xact_kind == KIND_PW && !src_par_bad)); // R8
  AST_SYS_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_flag && !clr_sys_flag) |=> sys_flag); // R10
  AST_DET_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !clr_det_flag) |=> det_flag); // R9
endmodule

// File: tb/bridge_parity_signal_bench.sv
module bridge_parity_signal_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic xact_valid = 0, xact_up = 0, err_on_sec = 0, par_bad = 0, src_par_bad = 0;
  logic [1:0] xact_kind = 0;
  logic pri_perr_seen = 0, sec_perr_seen = 0;
  logic pri_per_en = 1, sec_per_en = 1, serr_en = 1;
  logic clr_det_flag = 0, clr_sys_flag = 0;
  logic sec_perr_n, sec_perr_oe, pri_serr_oe, det_flag, sys_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_parity_signal u_bridge_parity_signal (
    .clk(clk), .rst_n(rst_n), .xact_valid(xact_valid), .xact_kind(xact_kind),
    .xact_up(xact_up), .err_on_sec(err_on_sec), .par_bad(par_bad),
    .src_par_bad(src_par_bad), .pri_perr_seen(pri_perr_seen),
    .sec_perr_seen(sec_perr_seen), .pri_per_en(pri_per_en),
    .sec_per_en(sec_per_en), .serr_en(serr_en), .clr_det_flag(clr_det_flag),
    .clr_sys_flag(clr_sys_flag), .sec_perr_n(sec_perr_n),
    .sec_perr_oe(sec_perr_oe), .pri_serr_oe(pri_serr_oe),
    .det_flag(det_flag), .sys_flag(sys_flag));

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    xact_valid = 0; xact_kind = 0; xact_up = 0; err_on_sec = 0; par_bad = 0;
    src_par_bad = 0; pri_perr_seen = 0; sec_perr_seen = 0;
    clr_det_flag = 0; clr_sys_flag = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_det_flag = 1; clr_sys_flag = 1;
    @(negedge clk); clr_det_flag = 0; clr_sys_flag = 0;
  endtask

  // present one descriptor, then check the five periods that follow its edge
  task automatic run_case(string req, logic [1:0] kind, logic up, logic on_sec,
                          logic bad, logic srcbad, logic pps, logic sps,
                          logic pen, logic sen, logic een,
                          logic exp_perr, logic exp_serr);
    clear_flags();
    repeat (4) @(negedge clk);
    xact_valid = 1; xact_kind = kind; xact_up = up; err_on_sec = on_sec;
    par_bad = bad; src_par_bad = srcbad; pri_perr_seen = pps; sec_perr_seen = sps;
    pri_per_en = pen; sec_per_en = sen; serr_en = een;
    @(posedge clk); #1;
    idle_inputs();
    chk(req, "serr s0", pri_serr_oe, exp_serr);
    chk(req, "perr_oe s0", sec_perr_oe, 1'b0);
    chk(req, "det_flag", det_flag, exp_perr);
    chk(req, "sys_flag", sys_flag, exp_serr);
    @(posedge clk); #1;
    chk(req, "serr s1", pri_serr_oe, 1'b0);
    chk(req, "perr_oe s1", sec_perr_oe, 1'b0);
    @(posedge clk); #1;
    chk(req, "perr_oe s2", sec_perr_oe, exp_perr);
    chk(req, "perr_n s2", sec_perr_n, !exp_perr);
    @(posedge clk); #1;
    chk(req, "perr_oe s3", sec_perr_oe, exp_perr);
    chk(req, "perr_n s3", sec_perr_n, 1'b1);
    @(posedge clk); #1;
    chk(req, "perr_oe s4", sec_perr_oe, 1'b0);
    pri_per_en = 1; sec_per_en = 1; serr_en = 1;
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "perr_oe", sec_perr_oe, 1'b0);
    chk("R1", "perr_n", sec_perr_n, 1'b1);
    chk("R1", "serr_oe", pri_serr_oe, 1'b0);
    chk("R1", "det_flag", det_flag, 1'b0);
    chk("R1", "sys_flag", sys_flag, 1'b0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    xact_valid = 1; xact_kind = 2'd0; xact_up = 0; err_on_sec = 1; par_bad = 1;
    @(posedge clk); #1;
    xact_kind = 2'd1; xact_up = 1;
    @(posedge clk); #1;
    idle_inputs();
    @(posedge clk); #1;
    chk("R11", "first low n", sec_perr_n, 1'b0);
    @(posedge clk); #1;
    chk("R11", "second low n", sec_perr_n, 1'b0);
    chk("R11", "second low oe", sec_perr_oe, 1'b1);
    @(posedge clk); #1;
    chk("R11", "high n", sec_perr_n, 1'b1);
    chk("R11", "high oe", sec_perr_oe, 1'b1);
    @(posedge clk); #1;
    chk("R11", "released", sec_perr_oe, 1'b0);
  endtask

  task automatic test_flags();
    clear_flags();
    #1;
    chk("R9", "det cleared", det_flag, 1'b0);
    chk("R10", "sys cleared", sys_flag, 1'b0);
    @(negedge clk);
    xact_valid = 1; xact_kind = 2'd0; err_on_sec = 1; par_bad = 1;
    @(posedge clk); #1; idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "det holds", det_flag, 1'b1);
    @(negedge clk);
    xact_valid = 1; xact_kind = 2'd0; err_on_sec = 1; par_bad = 1; clr_det_flag = 1;
    @(posedge clk); #1; idle_inputs();
    chk("R9", "set wins over clear", det_flag, 1'b1);
    @(negedge clk); clr_det_flag = 1;
    @(posedge clk); #1; idle_inputs();
    chk("R9", "det cleared by pulse", det_flag, 1'b0);
    @(negedge clk);
    xact_valid = 1; xact_kind = 2'd1; xact_up = 1; pri_perr_seen = 1;
    @(posedge clk); #1; idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "sys holds", sys_flag, 1'b1);
    @(negedge clk);
    xact_valid = 1; xact_kind = 2'd1; xact_up = 1; pri_perr_seen = 1; clr_sys_flag = 1;
    @(posedge clk); #1; idle_inputs();
    chk("R10", "set wins over clear", sys_flag, 1'b1);
    @(negedge clk); clr_sys_flag = 1;
    @(posedge clk); #1; idle_inputs();
    chk("R10", "sys cleared by pulse", sys_flag, 1'b0);
  endtask

  initial begin
    test_reset();
    // kind up sec bad src pps sps pen sen een perr serr
    run_case("R2", 2'd0, 0, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0);
    run_case("R2", 2'd1, 1, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0);
    run_case("R2", 2'd2, 1, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0);
    run_case("R3", 2'd0, 1, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_case("R3", 2'd1, 0, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_case("R3", 2'd2, 0, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_case("R4", 2'd2, 1, 0, 0, 0, 1, 0, 1, 1, 1, 1, 0);
    run_case("R4", 2'd0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_case("R4", 2'd2, 1, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_case("R4", 2'd2, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    run_case("R5", 2'd0, 0, 1, 1, 0, 0, 0, 1, 0, 1, 0, 0);
    run_case("R5", 2'd2, 1, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    run_case("R6", 2'd1, 1, 1, 1, 0, 0, 0, 0, 1, 0, 1, 0);
    run_case("R7", 2'd1, 1, 0, 0, 0, 1, 0, 1, 1, 1, 0, 1);
    run_case("R7", 2'd1, 0, 1, 0, 0, 0, 1, 1, 1, 1, 0, 1);
    run_case("R8", 2'd1, 1, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0);
    run_case("R8", 2'd1, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0);
    run_case("R8", 2'd1, 0, 1, 0, 0, 0, 1, 0, 1, 1, 0, 0);
    run_case("R8", 2'd1, 1, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    run_case("R8", 2'd0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    test_back_to_back();
    test_flags();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule